// File: doc/BRIEF.md
# Dual-Port Mailbox Memory with Cross Interrupts

This block is a synchronous memory with two fully independent access ports, called left and right. Each port has its own active-low select, output enable and write strobe, plus an address, a 36-bit data bus and an active-low write-inhibit pin. Either port can read or write any word in any cycle. Reads are registered, so read data appears one clock after the request. Writes take effect at the clock edge.

The two top words serve as mailboxes between the two sides. A port that writes its outgoing mailbox pulls the other port's active-low interrupt low. The receiving port drops that interrupt by selecting its own incoming mailbox with its output enable active. The message itself is plain stored data. A parameter removes the interrupt function, and the two top words then act as plain memory.

The ports are plain pin-level interfaces with no valid/ready handshake. Every selected cycle is accepted, and no back-pressure is possible. The write-inhibit pin is the only way to refuse a write.

Top module: `mbox_dpram`

## Requirements
- R1: The left interrupt `l_int_n` goes low one clock after the right port writes address DEPTH-2. A write means select low, write strobe low and write-inhibit high.
- R2: The left interrupt returns high one clock after the left port has select low and output enable low at address DEPTH-2. The level of the left write strobe does not matter.
- R3: The right interrupt `r_int_n` goes low one clock after the left port writes address DEPTH-1. It returns high one clock after the right port has select low and output enable low at DEPTH-1.
- R4: Every word, the two mailboxes included, stores its full 36-bit value. A read returns that value on the port's read data one clock after the request. A read is select low, write strobe high and output enable low.
- R5: With IRQ_EN=0, both interrupts stay high at all times, and the two top addresses store and return data like any other word.
- R6: While a port's write-inhibit is low, that port's writes change no memory word and set no interrupt.
- R7: While a port's select is high, that port has no effect. It writes nothing, clears no interrupt, and its read data holds its previous value.
- R8: If an interrupt is set and cleared in the same cycle, it ends up set (low).
- R9: If both ports write the same address in the same cycle, the left port's data is kept.
- R10: After reset, both interrupts are high and both read-data buses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| l_ce_n | input | 1 | Left port select, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_wblk_n | input | 1 | Left write-inhibit, low blocks writes |
| l_addr | input | AW | Left address |
| l_wdata | input | DW | Left write data |
| l_rdata | output | DW | Left registered read data |
| l_int_n | output | 1 | Left interrupt, active low |
| r_ce_n | input | 1 | Right port select, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_wblk_n | input | 1 | Right write-inhibit, low blocks writes |
| r_addr | input | AW | Right address |
| r_wdata | input | DW | Right write data |
| r_rdata | output | DW | Right registered read data |
| r_int_n | output | 1 | Right interrupt, active low |

## Verification
The bench drives a clearing access and a new mailbox write into the same cycle. A design where the clear wins would lose the message notification. The bench clears an interrupt with a write access, which catches a design that accepts only reads as a clear. It also tries inhibited and deselected accesses at a mailbox, where a faulty design would raise or drop an interrupt or corrupt a stored word. It collides both ports on one address, where the wrong priority stores the right port's data. A second instance built with IRQ_EN=0 sees the same traffic, and any interrupt it raises or any mailbox word it fails to keep is caught.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // decoded per-port request, active high
  typedef struct packed {
    logic wr_en;  // accepted write
    logic rd_en;  // registered read request
    logic sel;    // selected with output enable (mailbox clear qualifier)
  } port_ctl_t;
endpackage

// File: rtl/mbox_port_dec.sv
module mbox_port_dec
  import mbox_pkg::*;
(
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      we_n,
  input  logic      wblk_n,
  output port_ctl_t ctl
);
  always_comb begin
    ctl.wr_en = !ce_n && !we_n && wblk_n;
    ctl.rd_en = !ce_n && we_n && !oe_n;
    ctl.sel   = !ce_n && !oe_n;
  end
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_o <= 1'b0;
    else if (set_i) irq_o <= 1'b1;   // set beats clear
    else if (clr_i) irq_o <= 1'b0;
  end
endmodule

// File: rtl/mbox_mem.sv
module mbox_mem #(
  parameter int DEPTH = 64,
  parameter int DW    = 36,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          wr,
  input  logic [1:0]          rd,
  input  logic [1:0][AW-1:0]  addr,
  input  logic [1:0][DW-1:0]  wdata,
  output logic [1:0][DW-1:0]  rdata
);
  logic [DW-1:0] mem [DEPTH];

  // index 0 = left; left assignment comes last so it wins a collision
  always_ff @(posedge clk) begin
    if (wr[1]) mem[addr[1]] <= wdata[1];
    if (wr[0]) mem[addr[0]] <= wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (rd[p]) rdata[p] <= mem[addr[p]];
      end
    end
  end
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram #(
  parameter int DEPTH  = 64,
  parameter int DW     = 36,
  parameter bit IRQ_EN = 1'b1,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_ce_n,
  input  logic          l_oe_n,
  input  logic          l_we_n,
  input  logic          l_wblk_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_int_n,
  input  logic          r_ce_n,
  input  logic          r_oe_n,
  input  logic          r_we_n,
  input  logic          r_wblk_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_int_n
);
  import mbox_pkg::*;

  logic [1:0]          ce_v, oe_v, we_v, blk_v, wr_v, rd_v, irq_v;
  logic [1:0][AW-1:0]  addr_v;
  logic [1:0][DW-1:0]  wd_v, rd_data;
  port_ctl_t           ctl [2];

  assign ce_v   = {r_ce_n, l_ce_n};
  assign oe_v   = {r_oe_n, l_oe_n};
  assign we_v   = {r_we_n, l_we_n};
  assign blk_v  = {r_wblk_n, l_wblk_n};
  assign addr_v = {r_addr, l_addr};
  assign wd_v   = {r_wdata, l_wdata};

  for (genvar p = 0; p < 2; p++) begin : g_port
    // incoming mailbox: left owns DEPTH-2, right owns DEPTH-1
    localparam logic [AW-1:0] IN_MB = (p == 0) ? AW'(DEPTH - 2) : AW'(DEPTH - 1);

    mbox_port_dec u_dec (
      .ce_n   (ce_v[p]),
      .oe_n   (oe_v[p]),
      .we_n   (we_v[p]),
      .wblk_n (blk_v[p]),
      .ctl    (ctl[p])
    );

    assign wr_v[p] = ctl[p].wr_en;
    assign rd_v[p] = ctl[p].rd_en;

    if (IRQ_EN) begin : g_irq
      mbox_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ctl[1-p].wr_en && (addr_v[1-p] == IN_MB)),
        .clr_i (ctl[p].sel && (addr_v[p] == IN_MB)),
        .irq_o (irq_v[p])
      );
    end else begin : g_noirq
      assign irq_v[p] = 1'b0;
    end
  end

  mbox_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr_v),
    .rd    (rd_v),
    .addr  (addr_v),
    .wdata (wd_v),
    .rdata (rd_data)
  );

  assign l_rdata = rd_data[0];
  assign r_rdata = rd_data[1];
  assign l_int_n = ~irq_v[0];
  assign r_int_n = ~irq_v[1];
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
  parameter int DEPTH  = 64,
  parameter int DW     = 36,
  parameter bit IRQ_EN = 1'b1,
  localparam int AW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_ce_n,
  input logic          l_oe_n,
  input logic          l_we_n,
  input logic          l_wblk_n,
  input logic [AW-1:0] l_addr,
  input logic          l_int_n,
  input logic          r_ce_n,
  input logic          r_oe_n,
  input logic          r_we_n,
  input logic          r_wblk_n,
  input logic [AW-1:0] r_addr,
  input logic          r_int_n
);
  localparam logic [AW-1:0] MBL = AW'(DEPTH - 2);
  localparam logic [AW-1:0] MBR = AW'(DEPTH - 1);

  logic l_post, r_post, l_take, r_take;
  assign l_post = !l_ce_n && !l_we_n && l_wblk_n && (l_addr == MBR);
  assign r_post = !r_ce_n && !r_we_n && r_wblk_n && (r_addr == MBL);
  assign l_take = !l_ce_n && !l_oe_n && (l_addr == MBL);
  assign r_take = !r_ce_n && !r_oe_n && (r_addr == MBR);

  AST_LINT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (IRQ_EN && r_post) |=> !l_int_n);                      // R1
  AST_LINT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (l_take && !r_post) |=> l_int_n);                      // R2
  AST_RINT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (IRQ_EN && l_post) |=> !r_int_n);                      // R3
  AST_RINT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (r_take && !l_post) |=> r_int_n);                      // R3
  AST_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !IRQ_EN |-> (l_int_n && r_int_n));                     // R5
  AST_LINT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_int_n && $past(l_int_n)) |-> $past(r_post));       // R6
  AST_RINT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_int_n && $past(r_int_n)) |-> $past(l_post));       // R6
endmodule

bind mbox_dpram mbox_chk #(.DEPTH(DEPTH), .DW(DW), .IRQ_EN(IRQ_EN)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_ce_n(l_ce_n), .l_oe_n(l_oe_n), .l_we_n(l_we_n), .l_wblk_n(l_wblk_n),
  .l_addr(l_addr), .l_int_n(l_int_n),
  .r_ce_n(r_ce_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n), .r_wblk_n(r_wblk_n),
  .r_addr(r_addr), .r_int_n(r_int_n)
);

// File: tb/tb_mbox_dpram.sv
module tb_mbox_dpram;
  localparam int DEPTH = 64;
  localparam int DW    = 36;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [AW-1:0] MBL = AW'(DEPTH - 2);
  localparam logic [AW-1:0] MBR = AW'(DEPTH - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic l_ce_n, l_oe_n, l_we_n, l_wblk_n, r_ce_n, r_oe_n, r_we_n, r_wblk_n;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata, p_l_rdata, p_r_rdata;
  logic l_int_n, r_int_n, p_l_int_n, p_r_int_n;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  mbox_dpram #(.DEPTH(DEPTH), .DW(DW), .IRQ_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n),
    .l_ce_n(l_ce_n), .l_oe_n(l_oe_n), .l_we_n(l_we_n), .l_wblk_n(l_wblk_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_int_n(l_int_n),
    .r_ce_n(r_ce_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n), .r_wblk_n(r_wblk_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_int_n(r_int_n));

  mbox_dpram #(.DEPTH(DEPTH), .DW(DW), .IRQ_EN(1'b0)) dut_plain (
    .clk(clk), .rst_n(rst_n),
    .l_ce_n(l_ce_n), .l_oe_n(l_oe_n), .l_we_n(l_we_n), .l_wblk_n(l_wblk_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(p_l_rdata), .l_int_n(p_l_int_n),
    .r_ce_n(r_ce_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n), .r_wblk_n(r_wblk_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(p_r_rdata), .r_int_n(p_r_int_n));

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    {l_ce_n, l_oe_n, l_we_n, l_wblk_n} = 4'b1111;
    {r_ce_n, r_oe_n, r_we_n, r_wblk_n} = 4'b1111;
    l_addr = '0; r_addr = '0; l_wdata = '0; r_wdata = '0;
  endtask

  task automatic lset(input logic ce, oe, we, blk, input logic [AW-1:0] a, input logic [DW-1:0] d);
    {l_ce_n, l_oe_n, l_we_n, l_wblk_n} = {ce, oe, we, blk};
    l_addr = a; l_wdata = d;
  endtask

  task automatic rset(input logic ce, oe, we, blk, input logic [AW-1:0] a, input logic [DW-1:0] d);
    {r_ce_n, r_oe_n, r_we_n, r_wblk_n} = {ce, oe, we, blk};
    r_addr = a; r_wdata = d;
  endtask

  // inputs change at negedge, outputs sampled at the next negedge
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic lwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    lset(0, 1, 0, 1, a, d); step();
  endtask
  task automatic rwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    rset(0, 1, 0, 1, a, d); step();
  endtask
  task automatic lread(input logic [AW-1:0] a);
    lset(0, 0, 1, 1, a, '0); step();
  endtask
  task automatic rread(input logic [AW-1:0] a);
    rset(0, 0, 1, 1, a, '0); step();
  endtask

  task automatic t_reset();
    chk("R10 l_int_n after reset", DW'(l_int_n), DW'(1));
    chk("R10 r_int_n after reset", DW'(r_int_n), DW'(1));
    chk("R10 l_rdata after reset", l_rdata, '0);
    chk("R10 r_rdata after reset", r_rdata, '0);
  endtask

  task automatic t_basic();
    lwrite(6'd5, 36'hA_1234_5678);
    rread(6'd5);
    chk("R4 right reads left word", r_rdata, 36'hA_1234_5678);
    rwrite(6'd9, 36'h5_0F0F_0F0F);
    lread(6'd9);
    chk("R4 left reads right word", l_rdata, 36'h5_0F0F_0F0F);
  endtask

  task automatic t_lmail();
    rwrite(MBL, 36'hC_CAFE_0001);
    chk("R1 left int set", DW'(l_int_n), DW'(0));
    chk("R1 right int untouched", DW'(r_int_n), DW'(1));
    chk("R5 plain left int high", DW'(p_l_int_n), DW'(1));
    lread(MBL);
    chk("R4 left mailbox data", l_rdata, 36'hC_CAFE_0001);
    chk("R2 left int cleared by read", DW'(l_int_n), DW'(1));
    chk("R5 plain mailbox data", p_l_rdata, 36'hC_CAFE_0001);
    rwrite(MBL, 36'hC_CAFE_0002);
    chk("R1 left int set again", DW'(l_int_n), DW'(0));
    lset(0, 0, 0, 1, MBL, 36'h3_3333_3333); step();
    chk("R2 left int cleared by write access", DW'(l_int_n), DW'(1));
    lread(MBL);
    chk("R4 left mailbox after own write", l_rdata, 36'h3_3333_3333);
  endtask

  task automatic t_rmail();
    lwrite(MBR, 36'hF_0000_00FF);
    chk("R3 right int set", DW'(r_int_n), DW'(0));
    chk("R5 plain right int high", DW'(p_r_int_n), DW'(1));
    rread(MBR);
    chk("R3 right int cleared", DW'(r_int_n), DW'(1));
    chk("R4 right mailbox data", r_rdata, 36'hF_0000_00FF);
    chk("R5 plain right mailbox data", p_r_rdata, 36'hF_0000_00FF);
  endtask

  task automatic t_standby();
    lwrite(6'd7, 36'h0_7777_0000);
    rwrite(MBL, 36'h1_1111_1111);
    lread(6'd7);
    chk("R4 left read addr 7", l_rdata, 36'h0_7777_0000);
    lset(1, 0, 1, 1, MBL, '0); step();
    chk("R7 deselected clear ignored", DW'(l_int_n), DW'(0));
    chk("R7 deselected read holds data", l_rdata, 36'h0_7777_0000);
    rset(1, 1, 0, 1, 6'd7, 36'h9_9999_9999); step();
    lread(6'd7);
    chk("R7 deselected write ignored", l_rdata, 36'h0_7777_0000);
    lread(MBL);
    chk("R2 left int cleared", DW'(l_int_n), DW'(1));
  endtask

  task automatic t_inhibit();
    rset(0, 1, 0, 0, MBL, 36'hE_EEEE_EEEE); step();
    chk("R6 inhibited write sets no int", DW'(l_int_n), DW'(1));
    lread(MBL);
    chk("R6 inhibited write leaves mailbox", l_rdata, 36'h1_1111_1111);
    lwrite(6'd3, 36'h0_0000_0AAA);
    lset(0, 1, 0, 0, 6'd3, 36'h0_0000_0BBB); step();
    rread(6'd3);
    chk("R6 inhibited left write dropped", r_rdata, 36'h0_0000_0AAA);
    lset(0, 1, 0, 0, MBR, 36'h0_0000_0CCC); step();
    chk("R6 inhibited left write sets no int", DW'(r_int_n), DW'(1));
  endtask

  task automatic t_setwin();
    rwrite(MBL, 36'h2_0000_0001);
    rset(0, 1, 0, 1, MBL, 36'h2_0000_0002);
    lset(0, 0, 1, 1, MBL, '0);
    step();
    chk("R8 set wins over clear", DW'(l_int_n), DW'(0));
    chk("R4 same-cycle read sees old word", l_rdata, 36'h2_0000_0001);
    lread(MBL);
    chk("R2 cleared after", DW'(l_int_n), DW'(1));
    chk("R4 new word stored", l_rdata, 36'h2_0000_0002);
  endtask

  task automatic t_collide();
    lset(0, 1, 0, 1, 6'd11, 36'h4_AAAA_0000);
    rset(0, 1, 0, 1, 6'd11, 36'h4_BBBB_0000);
    step();
    rread(6'd11);
    chk("R9 left wins collision", r_rdata, 36'h4_AAAA_0000);
    lread(6'd11);
    chk("R9 left wins collision (left read)", l_rdata, 36'h4_AAAA_0000);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_lmail();
    t_rmail();
    t_standby();
    t_inhibit();
    t_setwin();
    t_collide();
    chk("R5 plain ints stay high", DW'({p_l_int_n, p_r_int_n}), DW'(2'b11));
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule